// File: doc/BRIEF.md
# Nested Prioritized Interrupt Arbiter

This block collects up to 43 external interrupt request lines. It chooses which one the processor should service next, and it tracks the handlers that are in progress so that they can nest. Each line has:

- an enable bit,
- a pending bit, set by a rising edge on its request,
- an active bit, set while its handler runs,
- a 4-bit priority, where 0 is the most urgent and 15 the least.

A small word-addressed register port lets software set and clear the enables, program the priorities and the grouping split, and read back the pending and active state.

Arbitration picks the most urgent line that is pending, enabled and not active. The lowest line number breaks ties. That winner is offered on `irq_take` / `irq_vector` in two cases: when no handler is running, or when the group part of its priority is strictly more urgent than the group part of the running handler. The processor answers with `irq_ack` to accept the offer and with `irq_eoi` when a handler finishes. An internal stack holds the vector and priority of every handler in progress, so that the preempted running priority comes back after each completion.

Top module: `irq_nest_arbiter`

Register map (word address on `reg_addr`):

| Address | Name | Write | Read |
|---|---|---|---|
| 0 | Enable set, lines 0..31 | 1 enables the line | Enable bits |
| 1 | Enable set, lines 32..63 | 1 enables the line | Enable bits |
| 2 | Enable clear, lines 0..31 | 1 disables the line | Enable bits |
| 3 | Enable clear, lines 32..63 | 1 disables the line | Enable bits |
| 4 | Pending, lines 0..31 | — | Pending bits |
| 5 | Pending, lines 32..63 | — | Pending bits |
| 6 | Active, lines 0..31 | — | Active bits |
| 7 | Active, lines 32..63 | — | Active bits |
| 8 | Grouping split | bits [2:0] | bits [2:0] |
| 16 + n/4 | Priority of line n | byte n%4 | byte n%4 |

In a priority word, the priority of line n sits in bits [8*(n%4)+7 : 8*(n%4)+4].

## Requirements
- R1: After reset, all enable, pending and active bits are 0, all priorities and the split read 0, and `irq_take` and `run_busy` are low.
- R2: Writing 1 to a bit at address 0/1 enables that line, and writing 1 at address 2/3 disables it. Bits written 0 have no effect. Addresses 0..3 read back the enables, and bits for lines 43 and above read 0.
- R3: The priority of line n is stored from bits [8*(n%4)+7 : 8*(n%4)+4] of the word at address 16+n/4. The low nibble of every byte, and the bytes of absent lines, read 0.
- R4: A rising edge on `irq_req[n]` sets pending bit n at the next clock edge, even when the line is disabled. A request held high does not set the bit again once it has been cleared.
- R5: A line whose enable is 0 is never presented on `irq_take`/`irq_vector`.
- R6: Among the lines that are pending, enabled and not active, the winner has the numerically lowest priority; on equal priority the lowest line number wins.
- R7: The number of subgroup bits is min(split, 4), and the group is the priority shifted right by that number of bits. While a handler runs, `irq_take` is high only if the winner's group is numerically below the running handler's group.
- R8: `irq_ack` while `irq_take` is high clears the winner's pending bit, sets its active bit, and makes `run_prio` equal to its priority. `irq_ack` while `irq_take` is low has no effect.
- R9: `irq_eoi` clears the active bit of the most recently acknowledged handler and restores `run_prio` to the handler below it, or drops `run_busy` when none is left. `irq_eoi` with no handler running has no effect.
- R10: When the acknowledged line sees a new rising edge in the same cycle, its pending bit stays set.
- R11: `irq_ack` and `irq_eoi` in the same cycle retire the current handler and start the offered one. `run_prio` becomes the new handler's priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 43 | Interrupt request lines, rising-edge sensitive |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_take | output | 1 | A request may be taken now |
| irq_vector | output | 6 | Line number of the offered request |
| irq_ack | input | 1 | Processor accepts the offered request |
| irq_eoi | input | 1 | Current handler has finished |
| run_busy | output | 1 | At least one handler is in progress |
| run_prio | output | 4 | Priority of the running handler (0 when idle) |

## Verification
Two pairs of functions can collide in one clock cycle.

The first pair is the edge detector setting a pending bit and the acknowledge clearing that same bit. The bench raises a request line in the very cycle it acknowledges that line. It then reads the pending and active registers, expecting both bits set, and expects the line to be offered again after the handler ends.

The second pair is the stack pop on end-of-handler and the stack push on acknowledge. The bench asserts `irq_eoi` and `irq_ack` together while a preempting request is offered. It judges the outcome from `run_prio`, `run_busy` and the active register, expecting the old handler's bit cleared and the new one's set.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W  = 4;
  localparam int SPLIT_W = 3;
  localparam int ADDR_W  = 5;

  localparam logic [ADDR_W-1:0] A_EN_SET0 = 5'd0;
  localparam logic [ADDR_W-1:0] A_EN_SET1 = 5'd1;
  localparam logic [ADDR_W-1:0] A_EN_CLR0 = 5'd2;
  localparam logic [ADDR_W-1:0] A_EN_CLR1 = 5'd3;
  localparam logic [ADDR_W-1:0] A_PEND0   = 5'd4;
  localparam logic [ADDR_W-1:0] A_PEND1   = 5'd5;
  localparam logic [ADDR_W-1:0] A_ACT0    = 5'd6;
  localparam logic [ADDR_W-1:0] A_ACT1    = 5'd7;
  localparam logic [ADDR_W-1:0] A_SPLIT   = 5'd8;
  localparam int                A_PRIO_BASE = 16;

  typedef logic [PRIO_W-1:0]  prio_t;
  typedef logic [SPLIT_W-1:0] split_t;

  // Number of low priority bits that only order pending requests.
  function automatic int sub_bits(input split_t split);
    return (int'(split) >= PRIO_W) ? PRIO_W : int'(split);
  endfunction

  // Part of a priority that takes part in preemption.
  function automatic prio_t group_of(input prio_t p, input split_t split);
    return p >> sub_bits(split);
  endfunction

  // True when a candidate may interrupt the running handler.
  function automatic logic preempts(input prio_t cand, input prio_t run, input split_t split);
    return group_of(cand, split) < group_of(run, split);
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 43
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_we,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [31:0]                    reg_wdata,
  output logic [31:0]                    reg_rdata,
  input  logic [NUM_IRQ-1:0]             irq_req,
  input  logic [NUM_IRQ-1:0]             act_set,
  input  logic [NUM_IRQ-1:0]             act_clr,
  output logic [NUM_IRQ-1:0]             en,
  output logic [NUM_IRQ-1:0]             pend,
  output logic [NUM_IRQ-1:0]             act,
  output logic [NUM_IRQ-1:0]             rise,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  output split_t                         split
);
  localparam int MAP_W = 64;

  logic [NUM_IRQ-1:0] req_q;
  assign rise = irq_req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      split <= '0;
    end else begin
      req_q <= irq_req;
      if (reg_we && reg_addr == A_SPLIT) split <= reg_wdata[SPLIT_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    localparam logic [ADDR_W-1:0] SET_A = (i < 32) ? A_EN_SET0 : A_EN_SET1;
    localparam logic [ADDR_W-1:0] CLR_A = (i < 32) ? A_EN_CLR0 : A_EN_CLR1;
    localparam logic [ADDR_W-1:0] PRI_A = ADDR_W'(A_PRIO_BASE + i / 4);
    localparam int BIT = i % 32;
    localparam int NIB = 8 * (i % 4) + (8 - PRIO_W);

    logic  en_r, pend_r, act_r;
    prio_t prio_r;
    logic  hit_set, hit_clr, hit_pri;

    assign hit_set = reg_we && (reg_addr == SET_A) && reg_wdata[BIT];
    assign hit_clr = reg_we && (reg_addr == CLR_A) && reg_wdata[BIT];
    assign hit_pri = reg_we && (reg_addr == PRI_A);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r   <= 1'b0;
        pend_r <= 1'b0;
        act_r  <= 1'b0;
        prio_r <= '0;
      end else begin
        if (hit_set)      en_r <= 1'b1;
        else if (hit_clr) en_r <= 1'b0;
        // a new edge outranks the acknowledge clear
        pend_r <= (pend_r & ~act_set[i]) | rise[i];
        act_r  <= (act_r & ~act_clr[i]) | act_set[i];
        if (hit_pri) prio_r <= reg_wdata[NIB +: PRIO_W];
      end
    end

    assign en[i]   = en_r;
    assign pend[i] = pend_r;
    assign act[i]  = act_r;
    assign prio[i] = prio_r;
  end

  logic [MAP_W-1:0] en_w, pend_w, act_w;
  assign en_w   = MAP_W'(en);
  assign pend_w = MAP_W'(pend);
  assign act_w  = MAP_W'(act);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN_SET0, A_EN_CLR0: reg_rdata = en_w[31:0];
      A_EN_SET1, A_EN_CLR1: reg_rdata = en_w[63:32];
      A_PEND0:              reg_rdata = pend_w[31:0];
      A_PEND1:              reg_rdata = pend_w[63:32];
      A_ACT0:               reg_rdata = act_w[31:0];
      A_ACT1:               reg_rdata = act_w[63:32];
      A_SPLIT:              reg_rdata[SPLIT_W-1:0] = split;
      default: begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          if (reg_addr == ADDR_W'(A_PRIO_BASE + i / 4))
            reg_rdata[8 * (i % 4) + (8 - PRIO_W) +: PRIO_W] = prio[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 43,
  parameter int VEC_W   = 6
) (
  input  logic [NUM_IRQ-1:0]             cand,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  output logic                           found,
  output logic [VEC_W-1:0]               win_vec,
  output prio_t                          win_prio
);
  // Ascending scan with strict compare: equal priority keeps the lower line.
  always_comb begin
    found    = 1'b0;
    win_vec  = '0;
    win_prio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!found || prio[i] < win_prio)) begin
        found    = 1'b1;
        win_vec  = VEC_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int VEC_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [VEC_W-1:0]           push_vec,
  input  prio_t                      push_prio,
  output logic                       busy,
  output logic [VEC_W-1:0]           top_vec,
  output prio_t                      top_prio,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    prio_t            prio;
  } frame_t;

  frame_t           stk [DEPTH];
  logic [CNT_W-1:0] sp;
  logic [IDX_W-1:0] top_idx, new_idx;
  logic             do_pop;
  frame_t           new_f;

  assign do_pop  = pop && (sp != '0);
  assign top_idx = IDX_W'(sp - 1'b1);
  assign new_idx = IDX_W'(sp);
  assign new_f   = '{vec: push_vec, prio: push_prio};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
    end else if (push && do_pop) begin
      stk[top_idx] <= new_f;
    end else if (push) begin
      stk[new_idx] <= new_f;
      sp           <= sp + 1'b1;
    end else if (do_pop) begin
      sp <= sp - 1'b1;
    end
  end

  assign busy     = (sp != '0);
  assign top_vec  = stk[top_idx].vec;
  assign top_prio = stk[top_idx].prio;
  assign level    = sp;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !do_pop) |-> (sp != CNT_W'(DEPTH))); // R8
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ     = 43,
  parameter int STACK_DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_req,
  input  logic                       reg_we,
  input  logic [4:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       irq_take,
  output logic [$clog2(NUM_IRQ)-1:0] irq_vector,
  input  logic                       irq_ack,
  input  logic                       irq_eoi,
  output logic                       run_busy,
  output logic [3:0]                 run_prio
);
  localparam int VEC_W = $clog2(NUM_IRQ);
  localparam int LVL_W = $clog2(STACK_DEPTH + 1);

  logic [NUM_IRQ-1:0]             en, pend, act, rise, cand, act_set, act_clr;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
  split_t                         split;
  logic                           found, busy, push, retire;
  logic [VEC_W-1:0]               win_vec, top_vec;
  prio_t                          win_prio, top_prio;
  logic [LVL_W-1:0]               level;

  irq_cfg_regs #(.NUM_IRQ(NUM_IRQ)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .act_set(act_set), .act_clr(act_clr), .en(en), .pend(pend), .act(act),
    .rise(rise), .prio(prio), .split(split)
  );

  assign cand = en & pend & ~act;

  irq_select #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_sel (
    .cand(cand), .prio(prio), .found(found), .win_vec(win_vec), .win_prio(win_prio)
  );

  irq_active_stack #(.DEPTH(STACK_DEPTH), .VEC_W(VEC_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(irq_eoi), .push_vec(win_vec),
    .push_prio(win_prio), .busy(busy), .top_vec(top_vec), .top_prio(top_prio),
    .level(level)
  );

  assign irq_take   = found && (!busy || preempts(win_prio, top_prio, split));
  assign irq_vector = win_vec;
  assign push       = irq_ack && irq_take;
  assign retire     = irq_eoi && busy;
  assign act_set    = push   ? (NUM_IRQ'(1) << win_vec) : '0;
  assign act_clr    = retire ? (NUM_IRQ'(1) << top_vec) : '0;
  assign run_busy   = busy;
  assign run_prio   = busy ? top_prio : '0;

  AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (en[irq_vector] && pend[irq_vector] && !act[irq_vector])); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rise[irq_vector]) |=> !pend[$past(irq_vector)]); // R8
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && rise[irq_vector]) |=> pend[$past(irq_vector)]); // R10
  AST_ACTIVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) == int'(level)); // R9
  AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_eoi && !busy && !irq_ack) |=> !busy); // R9
endmodule

// File: tb/irq_nest_arbiter_bench.sv
module irq_nest_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [42:0] irq_req = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_take;
  logic [5:0]  irq_vector;
  logic        irq_ack = 1'b0;
  logic        irq_eoi = 1'b0;
  logic        run_busy;
  logic [3:0]  run_prio;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_nest_arbiter u_irq_nest_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_take(irq_take), .irq_vector(irq_vector), .irq_ack(irq_ack),
    .irq_eoi(irq_eoi), .run_busy(run_busy), .run_prio(run_prio)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    step();
    d = reg_rdata;
  endtask

  task automatic pulse(input int n);
    irq_req[n] = 1'b1; step();
    irq_req[n] = 1'b0; step();
  endtask

  task automatic ack();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
  endtask

  task automatic eoi();
    irq_eoi = 1'b1; step(); irq_eoi = 1'b0;
  endtask

  task automatic expect_take(input string tag, input logic t, input int v);
    chk({tag, " take"}, {31'b0, irq_take}, {31'b0, t});
    if (t) chk({tag, " vector"}, {26'b0, irq_vector}, v);
  endtask

  task automatic cleanup();
    wr(5'd2, '1); wr(5'd3, '1); wr(5'd8, 0);
    for (int k = 16; k < 27; k++) wr(5'(k), 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 take", {31'b0, irq_take}, 0);
    chk("R1 busy", {31'b0, run_busy}, 0);
    rd(5'd0, d); chk("R1 en0", d, 0);
    rd(5'd1, d); chk("R1 en1", d, 0);
    rd(5'd4, d); chk("R1 pend0", d, 0);
    rd(5'd6, d); chk("R1 act0", d, 0);
    rd(5'd8, d); chk("R1 split", d, 0);
    rd(5'd16, d); chk("R1 prio", d, 0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(5'd0, 32'h5);          rd(5'd0, d); chk("R2 set", d, 32'h5);
    wr(5'd1, 32'hFFFF_FFFF);  rd(5'd1, d); chk("R2 upper absent", d, 32'h7FF);
    wr(5'd2, 32'h1);          rd(5'd0, d); chk("R2 clear", d, 32'h4);
    rd(5'd2, d);              chk("R2 clear-addr read", d, 32'h4);
    wr(5'd2, 32'h0);          rd(5'd0, d); chk("R2 zero no effect", d, 32'h4);
    wr(5'd0, 32'h0);          rd(5'd0, d); chk("R2 zero set no effect", d, 32'h4);
    wr(5'd2, '1); wr(5'd3, '1);
    rd(5'd1, d); chk("R2 clear upper", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(5'd16, 32'hA53C_F01E); rd(5'd16, d); chk("R3 nibble", d, 32'hA030_F010);
    wr(5'd26, 32'hFFFF_FFFF); rd(5'd26, d); chk("R3 absent byte", d, 32'h00F0_F0F0);
    wr(5'd16, 0); wr(5'd26, 0);
  endtask

  task automatic t_edge_disabled();
    logic [31:0] d;
    pulse(5);
    rd(5'd4, d); chk("R4 pend while disabled", d, 32'h20);
    expect_take("R5 disabled", 1'b0, 0);
    irq_req[5] = 1'b1; step();
    wr(5'd0, 32'h20);
    expect_take("R6 single", 1'b1, 5);
    ack();
    rd(5'd4, d); chk("R8 pend cleared", d, 0);
    rd(5'd6, d); chk("R8 active set", d, 32'h20);
    chk("R8 busy", {31'b0, run_busy}, 1);
    step(); step();
    rd(5'd4, d); chk("R4 level no reset", d, 0);
    irq_req[5] = 1'b0;
    eoi();
    chk("R9 busy low", {31'b0, run_busy}, 0);
    rd(5'd6, d); chk("R9 active cleared", d, 0);
    cleanup();
  endtask

  task automatic t_order();
    wr(5'd16, 32'h2000_0000);  // line 3 -> 2
    wr(5'd18, 32'h0000_2000);  // line 9 -> 2
    wr(5'd26, 32'h0000_0010);  // line 40 -> 1
    wr(5'd0, 32'h208); wr(5'd1, 32'h100);
    pulse(9); pulse(3);
    expect_take("R6 tie low line", 1'b1, 3);
    pulse(40);
    expect_take("R6 lowest prio", 1'b1, 40);
    ack();
    chk("R8 run_prio", {28'b0, run_prio}, 1);
    expect_take("R7 no preempt worse", 1'b0, 0);
    eoi();
    expect_take("R9 next after eoi", 1'b1, 3);
    ack();
    chk("R8 run_prio 2", {28'b0, run_prio}, 2);
    expect_take("R7 equal no preempt", 1'b0, 0);
    eoi();
    expect_take("R6 remaining", 1'b1, 9);
    ack(); eoi();
    expect_take("R6 drained", 1'b0, 0);
    cleanup();
  endtask

  task automatic t_group();
    logic [31:0] d;
    wr(5'd8, 2); rd(5'd8, d); chk("R7 split read", d, 2);
    wr(5'd16, 32'h0040_6000);  // line1 -> 6, line2 -> 4
    wr(5'd17, 32'h0000_0030);  // line4 -> 3
    wr(5'd0, 32'h16);
    pulse(1);
    expect_take("R7 idle take", 1'b1, 1);
    ack();
    chk("R8 prio 6", {28'b0, run_prio}, 6);
    pulse(2);
    expect_take("R7 same group blocked", 1'b0, 0);
    pulse(4);
    expect_take("R7 better group", 1'b1, 4);
    ack();
    chk("R8 nested prio", {28'b0, run_prio}, 3);
    eoi();
    chk("R9 restore", {28'b0, run_prio}, 6);
    expect_take("R7 still blocked", 1'b0, 0);
    eoi();
    expect_take("R7 after idle", 1'b1, 2);
    ack(); eoi();
    wr(5'd8, 5);
    pulse(1); ack();
    pulse(4);
    expect_take("R7 all subgroup", 1'b0, 0);
    eoi();
    expect_take("R7 all subgroup idle", 1'b1, 4);
    ack(); eoi();
    cleanup();
  endtask

  task automatic t_stray();
    logic [31:0] d;
    ack();
    chk("R8 stray ack busy", {31'b0, run_busy}, 0);
    rd(5'd6, d); chk("R8 stray ack active", d, 0);
    eoi();
    chk("R9 stray eoi", {31'b0, run_busy}, 0);
  endtask

  task automatic t_edge_ack();
    logic [31:0] d;
    wr(5'd0, 32'h40);
    pulse(6);
    expect_take("R10 offered", 1'b1, 6);
    irq_req[6] = 1'b1; irq_ack = 1'b1;
    step();
    irq_req[6] = 1'b0; irq_ack = 1'b0;
    rd(5'd4, d); chk("R10 pend kept", d, 32'h40);
    rd(5'd6, d); chk("R10 active", d, 32'h40);
    eoi();
    expect_take("R10 reoffered", 1'b1, 6);
    ack(); eoi();
    rd(5'd4, d); chk("R10 drained", d, 0);
    cleanup();
  endtask

  task automatic t_ack_eoi();
    logic [31:0] d;
    wr(5'd18, 32'h0010_0020);  // line8 -> 2, line10 -> 1
    wr(5'd0, 32'h500);
    pulse(8); ack();
    chk("R11 first prio", {28'b0, run_prio}, 2);
    pulse(10);
    expect_take("R11 preempt offered", 1'b1, 10);
    irq_ack = 1'b1; irq_eoi = 1'b1;
    step();
    irq_ack = 1'b0; irq_eoi = 1'b0;
    chk("R11 busy", {31'b0, run_busy}, 1);
    chk("R11 prio", {28'b0, run_prio}, 1);
    rd(5'd6, d); chk("R11 active swap", d, 32'h400);
    eoi();
    chk("R11 idle", {31'b0, run_busy}, 0);
    rd(5'd6, d); chk("R11 active empty", d, 0);
    cleanup();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_enables();
    t_prio();
    t_edge_disabled();
    t_order();
    t_group();
    t_stray();
    t_edge_ack();
    t_ack_eoi();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule